// File: doc/BRIEF.md
# Converter Channel Control Front End

This block is the register-facing control logic of a single-channel successive-approximation converter. Software writes a channel control word to pick an input. That write starts a conversion on the selected input, either at once or on the next external trigger pulse. The block keeps the returned code, raises a completion flag and, if enabled, an interrupt. A read of the result returns the code masked to the configured resolution. The analog part is replaced by a simple engine handshake: the block pulses `eng_start` with the input number, and the engine later pulses `eng_done` with a 12-bit code.

Two further modes sit on top of the one-shot conversion. Continuous mode starts the next conversion on the same input each time one finishes. An overwrite policy decides whether a fresh code replaces one that has not been read yet. A calibration request runs a fixed number of engine conversions, marked by `eng_cal`, and then completes through the same flag and interrupt. A separate failure bit records a request that was made while continuous mode was on.

Register map, 32-bit words at aligned byte offsets: 0x00 channel control, 0x04 status, 0x08 result, 0x0C configuration, 0x10 general control, 0x14 general status. All other offsets up to 0x30 read as zero, and offsets above 0x30 are not decoded and also read as zero.

Top module: `adcfe_top`

## Requirements
- R1: A write to channel control (0x00) with input select bits [4:0] not equal to 0x1F, in software-start mode, starts exactly one conversion with `eng_sel` equal to that select; bit 7 of the word is the interrupt enable.
- R2: Writing select 0x1F starts nothing, aborts a conversion in flight so that no result and no completion flag follow, and leaves the converter idle.
- R3: Status bit 0 is set when a conversion result is taken; `irq` is high exactly while this flag is 1 and channel-control bit 7 is 1.
- R4: Reading the result register clears the completion flag. Any channel-control write clears it and aborts a conversion in flight; a new select then starts a fresh conversion.
- R5: While general-control bit 6 is 1, each completed conversion immediately starts another on the same input; clearing the bit stops after the current conversion.
- R6: With configuration bit 16 at 1, a new code replaces an unread one; at 0, a code that arrives while the flag is set is discarded.
- R7: The result read returns the code masked by configuration bits [3:2]: 00 gives 8 bits, 01 gives 10 bits, 10 and 11 give 12 bits.
- R8: When configuration bit 13 and general-control bit 0 are both 1, a channel-control write only arms the converter and the conversion starts on the next `hw_trig` pulse; otherwise `hw_trig` is ignored and writes start at once.
- R9: Setting general-control bit 7 runs CAL_STEPS engine conversions with `eng_cal` high; at the end, bit 7 reads 0, general-status bit 1 reads 0 and the completion flag is set.
- R10: A calibration request made while continuous mode is on (in the current value or in the same write) runs no engine conversions, sets general-status bit 1 and the completion flag, and bit 7 reads 0 again.
- R11: A misaligned access (address bits [1:0] not 00) writes nothing and reads zero; undecoded offsets read zero.
- R12: After reset, channel control reads 0x1F, every other register reads 0 and `irq` is low.
- R13: While a calibration is running, a channel-control write stores the word but starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (result read clears the flag) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| hw_trig | input | 1 | External conversion trigger pulse |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle pulse telling the engine to drop its conversion |
| eng_cal | output | 1 | High while the engine works on calibration steps |
| eng_sel | output | 5 | Input to convert |
| eng_done | input | 1 | Engine completion pulse |
| eng_code | input | 12 | Engine result code, valid with eng_done |
| irq | output | 1 | Completion interrupt |

## Verification
The one-shot path is swept over all 31 live input selects, with engine latencies that vary from one select to the next. This separates select routing, flag timing and the clear-on-read behaviour from any fixed latency. The resolution field is tried in all four codes on codes that have their high bits set, so a wrong mask width shows up directly. Continuous runs are repeated with overwrite on and off: the result then equals either the last code or the first code after the flag was cleared, which tells the two policies apart. Aborts, trigger arming and both calibration outcomes are driven with engine start counts tracked at the ports, so that a conversion started when none should be shows up as a changed count.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
    localparam int SEL_W  = 5;
    localparam int CODE_W = 12;
    localparam int DATA_W = 32;

    localparam logic [SEL_W-1:0] SEL_OFF = '1;

    // register byte offsets
    localparam int OFF_CTRL  = 'h00;
    localparam int OFF_STAT  = 'h04;
    localparam int OFF_RES   = 'h08;
    localparam int OFF_CFG   = 'h0C;
    localparam int OFF_GCTL  = 'h10;
    localparam int OFF_GSTAT = 'h14;

    // bit positions decoded by the block
    localparam int B_IEN    = 7;
    localparam int B_OVW    = 16;
    localparam int B_HWTRIG = 13;
    localparam int B_RES_LO = 2;
    localparam int B_CAL    = 7;
    localparam int B_CONT   = 6;
    localparam int B_TRIGEN = 0;
    localparam int B_CALF   = 1;

    typedef enum logic [1:0] {
        RES8   = 2'b00,
        RES10  = 2'b01,
        RES12  = 2'b10,
        RES12X = 2'b11
    } res_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARMED,
        SQ_CONV,
        SQ_CAL
    } seq_state_e;

    typedef struct packed {
        logic             ien;
        logic [SEL_W-1:0] sel;
    } chan_ctl_t;

    typedef struct packed {
        logic      ovw;
        logic      hwtrig;
        res_mode_e res;
    } cfg_t;

    typedef struct packed {
        logic cal;
        logic cont;
        logic trig_en;
    } gctl_t;

    function automatic logic [CODE_W-1:0] mask_code(input logic [CODE_W-1:0] c,
                                                    input res_mode_e m);
        logic [CODE_W-1:0] r;
        case (m)
            RES8:    r = c & CODE_W'(12'h0FF);
            RES10:   r = c & CODE_W'(12'h3FF);
            default: r = c;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/adcfe_seq.sv
module adcfe_seq
    import adcfe_pkg::*;
#(
    parameter int CAL_STEPS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [SEL_W-1:0] sel,
    input  logic             cal_req,
    input  logic             cont,
    input  logic             hw_mode,
    input  logic             hw_trig,
    input  logic             eng_done,
    output logic             eng_start,
    output logic             eng_abort,
    output logic             eng_cal,
    output logic [SEL_W-1:0] eng_sel,
    output logic             conv_done,
    output logic             cal_done,
    output logic             cal_fail
);
    localparam int CNT_W = (CAL_STEPS > 1) ? $clog2(CAL_STEPS) : 1;

    seq_state_e       state;
    logic [CNT_W-1:0] step;
    logic             start_q, abort_q, cdone_q, cfail_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            step    <= '0;
            start_q <= 1'b0;
            abort_q <= 1'b0;
            cdone_q <= 1'b0;
            cfail_q <= 1'b0;
            sel_q   <= SEL_OFF;
        end else begin
            start_q <= 1'b0;
            abort_q <= 1'b0;
            cdone_q <= 1'b0;
            cfail_q <= 1'b0;
            if (cal_req && state != SQ_CAL) begin
                abort_q <= (state == SQ_CONV);
                if (cont) begin
                    state   <= SQ_IDLE;
                    cdone_q <= 1'b1;
                    cfail_q <= 1'b1;
                end else begin
                    state   <= SQ_CAL;
                    step    <= '0;
                    start_q <= 1'b1;
                end
            end else if (state == SQ_CAL) begin
                if (eng_done) begin
                    if (step == CNT_W'(CAL_STEPS - 1)) begin
                        state   <= SQ_IDLE;
                        cdone_q <= 1'b1;
                    end else begin
                        step    <= step + 1'b1;
                        start_q <= 1'b1;
                    end
                end
            end else if (ctl_wr) begin
                sel_q   <= sel;
                abort_q <= (state == SQ_CONV);
                if (sel == SEL_OFF) begin
                    state <= SQ_IDLE;
                end else if (hw_mode) begin
                    state <= SQ_ARMED;
                end else begin
                    state   <= SQ_CONV;
                    start_q <= 1'b1;
                end
            end else begin
                case (state)
                    SQ_ARMED: if (hw_trig && hw_mode) begin
                        state   <= SQ_CONV;
                        start_q <= 1'b1;
                    end
                    SQ_CONV: if (eng_done) begin
                        if (!cont) begin
                            state <= SQ_IDLE;
                        end else if (hw_mode) begin
                            state <= SQ_ARMED;
                        end else begin
                            start_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign conv_done = (state == SQ_CONV) && eng_done && !ctl_wr && !cal_req;
    assign eng_start = start_q;
    assign eng_abort = abort_q;
    assign eng_cal   = (state == SQ_CAL);
    assign eng_sel   = sel_q;
    assign cal_done  = cdone_q;
    assign cal_fail  = cfail_q;
endmodule

// File: rtl/adcfe_result.sv
module adcfe_result
    import adcfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [CODE_W-1:0] code,
    input  logic              ovw,
    input  logic              rd_clr,
    input  logic              wr_clr,
    input  logic              cal_set,
    output logic [CODE_W-1:0] result,
    output logic              cc
);
    logic take;
    assign take = conv_done && (!cc || ovw);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            cc     <= 1'b0;
        end else begin
            if (take) result <= code;
            if (wr_clr)            cc <= 1'b0;
            else if (take)         cc <= 1'b1;
            else if (cal_set)      cc <= 1'b1;
            else if (rd_clr)       cc <= 1'b0;
        end
    end
endmodule

// File: rtl/adcfe_top.sv
module adcfe_top
    import adcfe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CAL_STEPS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hw_trig,
    output logic              eng_start,
    output logic              eng_abort,
    output logic              eng_cal,
    output logic [SEL_W-1:0]  eng_sel,
    input  logic              eng_done,
    input  logic [CODE_W-1:0] eng_code,
    output logic              irq
);
    chan_ctl_t ctl_q;
    cfg_t      cfg_q;
    gctl_t     gctl_q;
    logic      calf_q;

    logic aligned, wr_ctl, wr_cfg, wr_gctl, rd_res, cal_req, hw_mode, ovw_en;
    logic conv_done, cal_done, cal_fail, cc, ien, gctl_cal;
    logic [CODE_W-1:0] result_q;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_ctl   = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_cfg   = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_CFG));
    assign wr_gctl  = bus_wr && aligned && (bus_addr == ADDR_W'(OFF_GCTL));
    assign rd_res   = bus_rd && aligned && (bus_addr == ADDR_W'(OFF_RES));
    assign cal_req  = wr_gctl && bus_wdata[B_CAL] && !gctl_q.cal;
    assign hw_mode  = cfg_q.hwtrig && gctl_q.trig_en;
    assign ovw_en   = cfg_q.ovw;
    assign ien      = ctl_q.ien;
    assign gctl_cal = gctl_q.cal;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{ien: 1'b0, sel: SEL_OFF};
            cfg_q  <= '{ovw: 1'b0, hwtrig: 1'b0, res: RES8};
            gctl_q <= '0;
            calf_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                ctl_q.ien <= bus_wdata[B_IEN];
                ctl_q.sel <= bus_wdata[SEL_W-1:0];
            end
            if (wr_cfg) begin
                cfg_q.ovw    <= bus_wdata[B_OVW];
                cfg_q.hwtrig <= bus_wdata[B_HWTRIG];
                cfg_q.res    <= res_mode_e'(bus_wdata[B_RES_LO +: 2]);
            end
            if (wr_gctl) begin
                gctl_q.cont    <= bus_wdata[B_CONT];
                gctl_q.trig_en <= bus_wdata[B_TRIGEN];
            end
            if (cal_done)     gctl_q.cal <= 1'b0;
            else if (cal_req) gctl_q.cal <= 1'b1;
            if (cal_done) calf_q <= cal_fail;
        end
    end

    adcfe_seq #(.CAL_STEPS(CAL_STEPS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (wr_ctl),
        .sel       (bus_wdata[SEL_W-1:0]),
        .cal_req   (cal_req),
        .cont      (gctl_q.cont || (wr_gctl && bus_wdata[B_CONT])),
        .hw_mode   (hw_mode),
        .hw_trig   (hw_trig),
        .eng_done  (eng_done),
        .eng_start (eng_start),
        .eng_abort (eng_abort),
        .eng_cal   (eng_cal),
        .eng_sel   (eng_sel),
        .conv_done (conv_done),
        .cal_done  (cal_done),
        .cal_fail  (cal_fail)
    );

    adcfe_result u_res (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .code      (eng_code),
        .ovw       (ovw_en),
        .rd_clr    (rd_res),
        .wr_clr    (wr_ctl),
        .cal_set   (cal_done),
        .result    (result_q),
        .cc        (cc)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr)
                ADDR_W'(OFF_CTRL): begin
                    bus_rdata[B_IEN]       = ctl_q.ien;
                    bus_rdata[SEL_W-1:0]   = ctl_q.sel;
                end
                ADDR_W'(OFF_STAT):  bus_rdata[0] = cc;
                ADDR_W'(OFF_RES):   bus_rdata[CODE_W-1:0] = mask_code(result_q, cfg_q.res);
                ADDR_W'(OFF_CFG): begin
                    bus_rdata[B_OVW]        = cfg_q.ovw;
                    bus_rdata[B_HWTRIG]     = cfg_q.hwtrig;
                    bus_rdata[B_RES_LO +: 2] = cfg_q.res;
                end
                ADDR_W'(OFF_GCTL): begin
                    bus_rdata[B_CAL]    = gctl_q.cal;
                    bus_rdata[B_CONT]   = gctl_q.cont;
                    bus_rdata[B_TRIGEN] = gctl_q.trig_en;
                end
                ADDR_W'(OFF_GSTAT): bus_rdata[B_CALF] = calf_q;
                default: ;
            endcase
        end
    end

    assign irq = cc && ctl_q.ien;
endmodule

// File: rtl/adcfe_chk.sv
module adcfe_chk
    import adcfe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_ctl,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              eng_start,
    input logic              eng_cal,
    input logic [SEL_W-1:0]  eng_sel,
    input logic              eng_done,
    input logic              cc,
    input logic [CODE_W-1:0] result_q,
    input logic              ovw_en,
    input logic              rd_res,
    input logic              cal_done,
    input logic              gctl_cal,
    input logic              irq,
    input logic              ien
);
    AST_START_LIVE_SEL: assert property (@(posedge clk) disable iff (rst)
        eng_start && !eng_cal |-> eng_sel != SEL_OFF); // R1

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
        wr_ctl && bus_wdata[SEL_W-1:0] == SEL_OFF |=> !eng_start); // R2

    AST_CTL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr_ctl |=> !cc); // R4

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        rd_res && !eng_done && !cal_done && !wr_ctl |=> !cc); // R4

    AST_KEEP_UNREAD: assert property (@(posedge clk) disable iff (rst)
        cc && !ovw_en |=> $stable(result_q)); // R6

    AST_CAL_STEP_HELD: assert property (@(posedge clk) disable iff (rst)
        eng_start && eng_cal |-> gctl_cal); // R9

    AST_CAL_END: assert property (@(posedge clk) disable iff (rst)
        cal_done && !wr_ctl |=> !gctl_cal && cc); // R9

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ien && cc); // R3
endmodule

bind adcfe_top adcfe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_ctl    (wr_ctl),
    .bus_wdata (bus_wdata),
    .eng_start (eng_start),
    .eng_cal   (eng_cal),
    .eng_sel   (eng_sel),
    .eng_done  (eng_done),
    .cc        (cc),
    .result_q  (result_q),
    .ovw_en    (ovw_en),
    .rd_res    (rd_res),
    .cal_done  (cal_done),
    .gctl_cal  (gctl_cal),
    .irq       (irq),
    .ien       (ien)
);

// File: tb/sim_adcfe_top.sv
module sim_adcfe_top;
    localparam int CAL_STEPS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_trig = 1'b0;
    logic        eng_start, eng_abort, eng_cal;
    logic [4:0]  eng_sel;
    logic        eng_done = 1'b0;
    logic [11:0] eng_code = '0;
    logic        irq;

    int nchk = 0, nerr = 0;
    int nstarts = 0, ncal = 0, ndone = 0;
    int lat = 3, cnt = 0;
    logic        pend_cal = 1'b0;
    logic [11:0] pend_code = '0;
    logic [4:0]  sel_seen = '0;
    logic [11:0] hist [0:511];
    bit finished = 0;

    always #5 clk = ~clk;

    adcfe_top #(.ADDR_W(8), .CAL_STEPS(CAL_STEPS)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_trig(hw_trig), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_cal(eng_cal), .eng_sel(eng_sel), .eng_done(eng_done),
        .eng_code(eng_code), .irq(irq)
    );

    // abstract conversion engine, acting between clock edges
    always @(negedge clk) begin
        if (eng_done) eng_done = 1'b0;
        if (eng_start) begin
            cnt       = lat;
            pend_cal  = eng_cal;
            pend_code = 12'((int'(eng_sel) * 131 + nstarts * 389 + 2900) % 4096);
            sel_seen  = eng_sel;
            nstarts++;
            if (eng_cal) ncal++;
        end else if (eng_abort) begin
            cnt = 0;
        end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
                eng_done = 1'b1;
                eng_code = pend_code;
                if (!pend_cal) begin
                    hist[ndone % 512] = pend_code;
                    ndone++;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (ndone < target && t < 600) begin
            @(negedge clk);
            t++;
        end
        idle(2);
    endtask

    function automatic logic [31:0] masked(input logic [11:0] c, input int m);
        if (m == 0) return {20'b0, c & 12'h0FF};
        if (m == 1) return {20'b0, c & 12'h3FF};
        return {20'b0, c};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int s0, d0, c0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R12: reset values
        rd(8'h00, d); chk("R12 ctrl", d, 32'h1F);
        rd(8'h04, d); chk("R12 stat", d, 0);
        rd(8'h08, d); chk("R12 res", d, 0);
        rd(8'h0C, d); chk("R12 cfg", d, 0);
        rd(8'h10, d); chk("R12 gctl", d, 0);
        rd(8'h14, d); chk("R12 gstat", d, 0);
        chk("R12 irq", irq, 0);

        // R1 R3 R4: one-shot sweep over every live select, 12-bit mode, overwrite on
        wr(8'h0C, 32'h0001_0008);
        for (int s = 0; s < 31; s++) begin
            lat = 1 + (s % 5);
            d0 = ndone;
            wr(8'h00, 32'h80 | s);
            wait_done(d0 + 1);
            chk("R1 sel", sel_seen, s);
            chk("R3 irq", irq, 1);
            rd(8'h04, d); chk("R3 flag", d, 1);
            rd(8'h08, d); chk("R7 code12", d, {20'b0, hist[(ndone - 1) % 512]});
            rd(8'h04, d); chk("R4 read clears", d, 0);
            chk("R4 irq low", irq, 0);
        end

        // R3: interrupt disabled leaves irq low while flag is set
        d0 = ndone;
        wr(8'h00, 32'h03);
        wait_done(d0 + 1);
        chk("R3 no ien irq", irq, 0);
        rd(8'h04, d); chk("R3 flag no ien", d, 1);
        rd(8'h08, d);

        // R7: resolution modes
        for (int m = 0; m < 4; m++) begin
            wr(8'h0C, 32'h0001_0000 | (m << 2));
            d0 = ndone;
            wr(8'h00, 32'h80 | (m + 20));
            wait_done(d0 + 1);
            rd(8'h08, d); chk("R7 mask", d, masked(hist[(ndone - 1) % 512], m));
        end
        wr(8'h0C, 32'h0001_0008);

        // R4: channel write clears an unread flag; R2: 0x1F starts nothing
        d0 = ndone;
        wr(8'h00, 32'h84);
        wait_done(d0 + 1);
        s0 = nstarts;
        wr(8'h00, 32'h9F);
        rd(8'h04, d); chk("R4 write clears", d, 0);
        idle(30);
        chk("R2 no start", nstarts, s0);

        // R2: abort in flight
        lat = 40;
        d0 = ndone; s0 = nstarts;
        wr(8'h00, 32'h82);
        idle(5);
        wr(8'h00, 32'h9F);
        idle(60);
        chk("R2 no result", ndone, d0);
        chk("R2 one start", nstarts, s0 + 1);
        rd(8'h04, d); chk("R2 flag clear", d, 0);

        // R4: abort and restart on a new select
        lat = 20;
        d0 = ndone;
        wr(8'h00, 32'h82);
        idle(5);
        wr(8'h00, 32'h89);
        wait_done(d0 + 1);
        idle(40);
        chk("R4 restart sel", sel_seen, 9);
        chk("R4 single result", ndone, d0 + 1);
        rd(8'h08, d); chk("R4 restart code", d, {20'b0, hist[d0 % 512]});

        // R5 R6: continuous with overwrite on
        lat = 3;
        d0 = ndone;
        wr(8'h10, 32'h40);
        wr(8'h00, 32'h86);
        wait_done(d0 + 5);
        wr(8'h10, 32'h00);
        idle(20);
        s0 = nstarts;
        idle(30);
        chk("R5 stopped", nstarts, s0);
        chk("R5 repeated", (ndone - d0 >= 5) ? 1 : 0, 1);
        chk("R5 same sel", sel_seen, 6);
        rd(8'h08, d); chk("R6 overwrite on", d, {20'b0, hist[(ndone - 1) % 512]});

        // R6: continuous with overwrite off keeps the first code
        wr(8'h0C, 32'h0000_0008);
        d0 = ndone;
        wr(8'h10, 32'h40);
        wr(8'h00, 32'h05);
        wait_done(d0 + 4);
        wr(8'h10, 32'h00);
        idle(30);
        rd(8'h08, d); chk("R6 overwrite off", d, {20'b0, hist[d0 % 512]});
        wr(8'h0C, 32'h0001_0008);

        // R8: hardware trigger arming
        wr(8'h0C, 32'h0000_2008);
        wr(8'h10, 32'h01);
        s0 = nstarts; d0 = ndone;
        wr(8'h00, 32'h87);
        idle(10);
        chk("R8 armed only", nstarts, s0);
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
        wait_done(d0 + 1);
        chk("R8 trig start", nstarts, s0 + 1);
        chk("R8 trig sel", sel_seen, 7);
        rd(8'h08, d); chk("R8 trig code", d, {20'b0, hist[d0 % 512]});
        // trigger enable without the configuration bit: software start, trigger ignored
        wr(8'h0C, 32'h0000_0008);
        s0 = nstarts; d0 = ndone;
        wr(8'h00, 32'h88);
        wait_done(d0 + 1);
        chk("R8 soft start", nstarts, s0 + 1);
        rd(8'h08, d);
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
        idle(20);
        chk("R8 trig ignored", nstarts, s0 + 1);
        wr(8'h10, 32'h00);

        // R9: calibration
        wr(8'h00, 32'h9F);
        c0 = ncal; s0 = nstarts;
        wr(8'h10, 32'h80);
        rd(8'h10, d); chk("R9 busy bit", d, 32'h80);
        wr(8'h00, 32'h83);
        for (int t = 0; t < 300 && !irq; t++) @(negedge clk);
        idle(2);
        chk("R9 cal steps", ncal, c0 + CAL_STEPS);
        chk("R13 no start", nstarts, s0 + CAL_STEPS);
        rd(8'h10, d); chk("R9 bit clears", d, 0);
        rd(8'h14, d); chk("R9 no fail", d, 0);
        rd(8'h04, d); chk("R9 flag", d, 1);
        chk("R9 irq", irq, 1);

        // R10: calibration refused in continuous mode
        wr(8'h00, 32'h9F);
        c0 = ncal;
        wr(8'h10, 32'hC0);
        idle(5);
        rd(8'h14, d); chk("R10 fail bit", d, 32'h2);
        rd(8'h10, d); chk("R10 bit clears", d, 32'h40);
        rd(8'h04, d); chk("R10 flag", d, 1);
        chk("R10 no steps", ncal, c0);
        wr(8'h10, 32'h00);
        wr(8'h10, 32'h80);
        idle(100);
        rd(8'h14, d); chk("R9 fail cleared", d, 0);

        // R11: alignment and decoding
        wr(8'h0D, 32'h0001_0000);
        rd(8'h0C, d); chk("R11 misaligned wr", d, 32'h8);
        rd(8'h0D, d); chk("R11 misaligned rd", d, 0);
        rd(8'h20, d); chk("R11 hole", d, 0);
        rd(8'h34, d); chk("R11 beyond", d, 0);
        s0 = nstarts;
        wr(8'h01, 32'h03);
        idle(10);
        chk("R11 misaligned ctrl", nstarts, s0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule